// File: doc/BRIEF.md
# Programmable Trigger Delay and Gate-Width Generator

This block turns an asynchronous sync trigger into a single gate pulse. The pulse starts after a delay that software or switches set, and it lasts for a width that is also set from outside. All timing is counted in ticks of a fast reference clock, and one tick is one fine delay step. The delay is the sum of two parts. The first is a fine byte worth 0 to 255 ticks. The second is a coarse offset chosen by a one-hot selector, worth 0, 250 or 500 ticks. The width is a 12-bit count multiplied by one of two tick increments, 5 or 50.

The trigger passes through a synchronizer. It is then held by a retriggerable stretcher so that a short input pulse still covers the whole fine-delay window. The raw synchronized level is ORed with the stretcher output, so the stretch logic adds no latency. A cycle starts on a rising edge of that held level, and only while the block is idle. The delay and width settings are captured at that instant. The busy output covers the delay phase and the gate phase.

Top module: `trig_gate_gen`

## Requirements
- R1: A synchronous reset, even in the middle of a cycle, forces gate and busy low at the next clock edge. It also clears the synchronizer, the stretcher and all counters, so a trigger after reset is accepted at once.
- R2: With a total delay of D ticks, gate goes high after the (D+4)th rising clock edge counted from the first edge at which sync_in is sampled high. The count includes the 2-stage synchronizer.
- R3: The total delay D is fine_dly plus a coarse offset taken from coarse_sel. The offset is 250 when coarse_sel is 4'b0010 and 500 when it is 4'b0100. It is 0 when coarse_sel is 4'b0001 or 4'b1000. Any other coarse_sel value, including zero and any value with two or more bits set, is illegal and is treated as offset 0.
- R4: The gate stays high for width_cnt × 5 ticks when inc_sel is 0, and for width_cnt × 50 ticks when inc_sel is 1.
- R5: A width_cnt of zero produces no gate pulse. Busy still falls after the (D+4)th edge.
- R6: Busy rises after the 3rd edge counted from the first high sample of sync_in. It stays high through the delay and the gate, and falls on the same edge that ends the gate.
- R7: A sync_in pulse only one clock period long is accepted.
- R8: The trigger is held for 256 ticks after the last edge at which the synchronized trigger was high. Each new high sample restarts that window. A new cycle needs the held level to fall and then rise again.
- R9: A trigger that arrives while busy is high does not start a cycle, either then or after the gate ends.
- R10: Changing fine_dly, coarse_sel, width_cnt or inc_sel after a cycle has been accepted does not change that cycle's delay or width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one period is one delay tick |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Asynchronous sync trigger |
| fine_dly | input | 8 | Fine delay in ticks |
| coarse_sel | input | 4 | One-hot coarse offset selector |
| width_cnt | input | 12 | Gate width count |
| inc_sel | input | 1 | Width increment select: 0 gives 5 ticks, 1 gives 50 ticks |
| gate | output | 1 | Gate pulse |
| busy | output | 1 | High while a delay or gate cycle is in progress |

## Verification
The hardest case to reach from the ports is the retrigger of the stretcher. Its window is invisible except through which later triggers get accepted. The stimulus first completes a short cycle. It then pulses sync_in about 150 ticks later, inside the first window, and pulses it again about 200 ticks after that. The second pulse falls after the first window would have expired but inside the restarted one. Busy must stay low through this, and a trigger sent once the window has lapsed must start a cycle again. A similar sequence lands a trigger during a long gate, after the stretch has run out, to show that the trigger is not queued.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_GATE  = 2'd2
  } tg_state_e;

  // bit positions inside the coarse selector
  localparam int CSEL_W    = 4;
  localparam int CSEL_ZERO = 0;
  localparam int CSEL_LO   = 1;
  localparam int CSEL_HI   = 2;
  localparam int CSEL_OFF  = 3;
endpackage

// File: rtl/tg_trig_cond.sv
module tg_trig_cond #(
  parameter int SYNC_STAGES   = 2,
  parameter int STRETCH_TICKS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic trig_seen,
  output logic trig_held,
  output logic trig_edge
);
  localparam int SC_W = $clog2(STRETCH_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_sh;
  logic [SC_W-1:0]        stretch_cnt;
  logic                   held_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= sync_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= {sync_sh[SYNC_STAGES-2:0], sync_in};
      end
    end
  endgenerate

  assign trig_seen = sync_sh[SYNC_STAGES-1];

  // retriggerable stretch: reload on every high sample
  always_ff @(posedge clk) begin
    if (rst)                    stretch_cnt <= '0;
    else if (trig_seen)         stretch_cnt <= SC_W'(STRETCH_TICKS - 1);
    else if (stretch_cnt != '0) stretch_cnt <= stretch_cnt - 1'b1;
  end

  // raw level ORed in so the stretch adds no latency
  assign trig_held = trig_seen | (stretch_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= trig_held;
  end

  assign trig_edge = trig_held & ~held_q;
endmodule

// File: rtl/tg_calc.sv
module tg_calc
  import tg_pkg::*;
#(
  parameter int FINE_W    = 8,
  parameter int WCNT_W    = 12,
  parameter int COARSE_LO = 250,
  parameter int COARSE_HI = 500,
  parameter int INC_SMALL = 5,
  parameter int INC_LARGE = 50,
  parameter int DLY_W     = 10,
  parameter int WID_W     = 18
) (
  input  logic [FINE_W-1:0] fine_dly,
  input  logic [CSEL_W-1:0] coarse_sel,
  input  logic [WCNT_W-1:0] width_cnt,
  input  logic              inc_sel,
  output logic [DLY_W-1:0]  dly_ticks,
  output logic [WID_W-1:0]  wid_ticks
);
  function automatic logic [DLY_W-1:0] coarse_ticks(input logic [CSEL_W-1:0] sel);
    logic [DLY_W-1:0] r;
    r = '0;
    if ($countones(sel) == 1) begin
      if (sel[CSEL_LO])      r = DLY_W'(COARSE_LO);
      else if (sel[CSEL_HI]) r = DLY_W'(COARSE_HI);
      else                   r = '0;
    end
    return r;
  endfunction

  function automatic logic [DLY_W-1:0] total_delay(input logic [FINE_W-1:0] f,
                                                   input logic [CSEL_W-1:0] sel);
    return DLY_W'(f) + coarse_ticks(sel);
  endfunction

  function automatic logic [WID_W-1:0] width_ticks(input logic [WCNT_W-1:0] w,
                                                   input logic big);
    logic [WID_W-1:0] step;
    step = big ? WID_W'(INC_LARGE) : WID_W'(INC_SMALL);
    return WID_W'(w) * step;
  endfunction

  assign dly_ticks = total_delay(fine_dly, coarse_sel);
  assign wid_ticks = width_ticks(width_cnt, inc_sel);
endmodule

// File: rtl/tg_seq.sv
module tg_seq
  import tg_pkg::*;
#(
  parameter int DLY_W = 10,
  parameter int WID_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_edge,
  input  logic [DLY_W-1:0] dly_in,
  input  logic [WID_W-1:0] wid_in,
  output logic             gate,
  output logic             busy,
  output logic             accept_evt,
  output logic             delay_done,
  output logic             width_zero,
  output logic             gate_last
);
  tg_state_e        state;
  logic [DLY_W-1:0] dcnt;
  logic [WID_W-1:0] wcnt;

  assign accept_evt = (state == ST_IDLE) & trig_edge;
  assign delay_done = (state == ST_DELAY) & (dcnt == '0);
  assign width_zero = (wcnt == '0);
  assign gate_last  = (state == ST_GATE) & (wcnt <= WID_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      dcnt  <= '0;
      wcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept_evt) begin
            state <= ST_DELAY;
            dcnt  <= dly_in;
            wcnt  <= wid_in;
          end
        end
        ST_DELAY: begin
          if (dcnt == '0) state <= width_zero ? ST_IDLE : ST_GATE;
          else            dcnt  <= dcnt - 1'b1;
        end
        ST_GATE: begin
          if (gate_last) begin
            state <= ST_IDLE;
            wcnt  <= '0;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign gate = (state == ST_GATE);
  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/trig_gate_gen.sv
module trig_gate_gen
  import tg_pkg::*;
#(
  parameter int FINE_W        = 8,
  parameter int WCNT_W        = 12,
  parameter int COARSE_LO     = 250,
  parameter int COARSE_HI     = 500,
  parameter int INC_SMALL     = 5,
  parameter int INC_LARGE     = 50,
  parameter int SYNC_STAGES   = 2,
  parameter int STRETCH_TICKS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic [FINE_W-1:0] fine_dly,
  input  logic [3:0]        coarse_sel,
  input  logic [WCNT_W-1:0] width_cnt,
  input  logic              inc_sel,
  output logic              gate,
  output logic              busy
);
  localparam int DLY_W = $clog2(COARSE_HI + (1 << FINE_W));
  localparam int WID_W = $clog2(((1 << WCNT_W) - 1) * INC_LARGE + 1);

  logic             w_seen, w_held, w_edge;
  logic [DLY_W-1:0] w_dly;
  logic [WID_W-1:0] w_wid;
  logic             w_accept, w_ddone, w_wzero, w_glast;

  tg_trig_cond #(
    .SYNC_STAGES  (SYNC_STAGES),
    .STRETCH_TICKS(STRETCH_TICKS)
  ) u_cond (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (sync_in),
    .trig_seen(w_seen),
    .trig_held(w_held),
    .trig_edge(w_edge)
  );

  tg_calc #(
    .FINE_W   (FINE_W),
    .WCNT_W   (WCNT_W),
    .COARSE_LO(COARSE_LO),
    .COARSE_HI(COARSE_HI),
    .INC_SMALL(INC_SMALL),
    .INC_LARGE(INC_LARGE),
    .DLY_W    (DLY_W),
    .WID_W    (WID_W)
  ) u_calc (
    .fine_dly  (fine_dly),
    .coarse_sel(coarse_sel),
    .width_cnt (width_cnt),
    .inc_sel   (inc_sel),
    .dly_ticks (w_dly),
    .wid_ticks (w_wid)
  );

  tg_seq #(
    .DLY_W(DLY_W),
    .WID_W(WID_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .trig_edge (w_edge),
    .dly_in    (w_dly),
    .wid_in    (w_wid),
    .gate      (gate),
    .busy      (busy),
    .accept_evt(w_accept),
    .delay_done(w_ddone),
    .width_zero(w_wzero),
    .gate_last (w_glast)
  );
endmodule

// File: rtl/tg_chk.sv
module tg_chk (
  input logic clk,
  input logic rst,
  input logic gate,
  input logic busy,
  input logic trig_seen,
  input logic trig_held,
  input logic accept_evt,
  input logic delay_done,
  input logic width_zero,
  input logic gate_last
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!gate && !busy));

  // R6
  gate_in_busy_chk: assert property (@(posedge clk) disable iff (rst) gate |-> busy);

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> (busy && !gate));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(accept_evt));

  // R4
  gate_start_chk: assert property (@(posedge clk) disable iff (rst)
    (delay_done && !width_zero) |=> gate);

  // R5
  zero_width_chk: assert property (@(posedge clk) disable iff (rst)
    (delay_done && width_zero) |=> (!gate && !busy));

  // R4
  gate_end_chk: assert property (@(posedge clk) disable iff (rst)
    gate_last |=> (!gate && !busy));

  // R6
  gate_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gate) |-> !busy);

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trig_seen |=> trig_held);
endmodule

bind trig_gate_gen tg_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .gate      (gate),
  .busy      (busy),
  .trig_seen (w_seen),
  .trig_held (w_held),
  .accept_evt(w_accept),
  .delay_done(w_ddone),
  .width_zero(w_wzero),
  .gate_last (w_glast)
);

// File: tb/sim_trig_gate_gen.sv
`timescale 1ns/1ps
module sim_trig_gate_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_in = 1'b0;
  logic [7:0]  fine_dly = '0;
  logic [3:0]  coarse_sel = 4'b0001;
  logic [11:0] width_cnt = '0;
  logic        inc_sel = 1'b0;
  logic        gate, busy;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  trig_gate_gen u0 (
    .clk(clk), .rst(rst), .sync_in(sync_in), .fine_dly(fine_dly),
    .coarse_sel(coarse_sel), .width_cnt(width_cnt), .inc_sel(inc_sel),
    .gate(gate), .busy(busy)
  );

  // fine, coarse, count, inc, expected delay, expected gate length
  localparam logic [52:0] VEC [8] = '{
    {8'd0,   4'b0001, 12'd1,    1'b0, 10'd0,   18'd5},
    {8'd10,  4'b0010, 12'd3,    1'b0, 10'd260, 18'd15},
    {8'd255, 4'b0100, 12'd2,    1'b1, 10'd755, 18'd100},
    {8'd7,   4'b1000, 12'd4095, 1'b0, 10'd7,   18'd20475},
    {8'd20,  4'b0110, 12'd2,    1'b1, 10'd20,  18'd100},
    {8'd5,   4'b0000, 12'd1,    1'b1, 10'd5,   18'd50},
    {8'd100, 4'b0010, 12'd0,    1'b0, 10'd350, 18'd0},
    {8'd33,  4'b0100, 12'd17,   1'b1, 10'd533, 18'd850}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_wait(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  // one-cycle trigger pulse, then measure; n counts posedges since sync rose
  task automatic run_cycle(input logic [7:0] f, input logic [3:0] c,
                           input logic [11:0] w, input logic i,
                           input int exp_d, input int exp_l, input bit disturb);
    int rise_n = -1, fall_n = -1, brise = -1, bfall = -1;
    @(negedge clk);
    fine_dly = f; coarse_sel = c; width_cnt = w; inc_sel = i;
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;  // R7: pulse of one clock period
    for (int n = 1; n <= exp_d + exp_l + 40; n++) begin
      if (gate && rise_n < 0) rise_n = n;
      if (!gate && rise_n >= 0 && fall_n < 0) fall_n = n;
      if (busy && brise < 0) brise = n;
      if (!busy && brise >= 0 && bfall < 0) bfall = n;
      if (disturb && n == 6) begin  // R10: change settings mid-cycle
        fine_dly = ~f; coarse_sel = 4'b0100; width_cnt = w + 12'd9; inc_sel = ~i;
      end
      @(negedge clk);
    end
    check(brise == 3, "R6", "busy rise edge", brise, 3);
    if (exp_l > 0) begin
      check(rise_n == exp_d + 4, "R2/R3", "gate rise edge", rise_n, exp_d + 4);
      check(fall_n - rise_n == exp_l, "R4", "gate length", fall_n - rise_n, exp_l);
    end else begin
      check(rise_n == -1, "R5", "gate on zero width", rise_n, -1);
    end
    check(bfall == exp_d + 4 + exp_l, "R6/R10", "busy fall edge", bfall, exp_d + 4 + exp_l);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(gate == 1'b0, "R1", "gate after reset", gate, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    rst = 1'b0;
    idle_wait(5);

    // vector table walk, settings disturbed mid-cycle
    for (int k = 0; k < 8; k++) begin
      run_cycle(VEC[k][52:45], VEC[k][44:41], VEC[k][40:29], VEC[k][28],
                int'(VEC[k][27:18]), int'(VEC[k][17:0]), 1'b1);
      idle_wait(300);
    end

    // R9: trigger during a long gate, after the stretch has lapsed
    begin
      int fall_n = -1, brises = 0;
      bit bprev = 1'b0;
      @(negedge clk);
      fine_dly = 8'd0; coarse_sel = 4'b0001; width_cnt = 12'd100; inc_sel = 1'b0;
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      for (int n = 1; n <= 900; n++) begin
        if (busy && !bprev) brises++;
        bprev = busy;
        if (n > 4 && !gate && fall_n < 0) fall_n = n;
        if (n == 400) sync_in = 1'b1;
        if (n == 401) sync_in = 1'b0;
        @(negedge clk);
      end
      check(fall_n == 504, "R9", "gate end with trigger in gate", fall_n, 504);
      check(brises == 1, "R9", "cycles started", brises, 1);
    end
    idle_wait(300);

    // R8: retrigger extends the stretch window
    begin
      int brises = 0;
      bit bprev = 1'b0;
      @(negedge clk);
      fine_dly = 8'd0; coarse_sel = 4'b0001; width_cnt = 12'd1; inc_sel = 1'b0;
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      for (int n = 1; n <= 450; n++) begin
        if (busy && !bprev) brises++;
        bprev = busy;
        if (n == 150 || n == 350) sync_in = 1'b1;
        if (n == 151 || n == 351) sync_in = 1'b0;
        @(negedge clk);
      end
      check(brises == 1, "R8", "cycles started in retriggered window", brises, 1);
    end
    idle_wait(300);
    // R8: after the window lapses a trigger is accepted again
    run_cycle(8'd3, 4'b0001, 12'd2, 1'b0, 3, 10, 1'b0);
    idle_wait(300);

    // R1: reset in mid-gate
    @(negedge clk);
    fine_dly = 8'd0; coarse_sel = 4'b0001; width_cnt = 12'd50; inc_sel = 1'b1;
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    idle_wait(20);
    check(gate == 1'b1, "R1", "gate before mid reset", gate, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(gate == 1'b0, "R1", "gate after mid reset", gate, 0);
    check(busy == 1'b0, "R1", "busy after mid reset", busy, 0);
    idle_wait(3);
    // stretcher cleared by reset, so a new trigger is accepted right away
    run_cycle(8'd2, 4'b1000, 12'd3, 1'b0, 2, 15, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule